// File: doc/BRIEF.md
# Process-Tagged Virtually Addressed Cache

This block is a direct-mapped data cache that is looked up with the virtual word address. Translation to a physical address is not on the hit path. Each line records the virtual tag, the process number that filled it, and the physical block number it was filled from. When process tagging is on, a hit needs both the virtual tag and the process number to match the current request. Because of this, switching between processes leaves the cache contents in place. When tagging is off, the first lookup made under a process number different from the previous lookup sweeps every line invalid before the lookup goes on.

On a miss, the block pulses a miss request and translates the address with an internal stub. The stub forms the physical address as the byte address XOR the process number shifted left by `PAGE_BITS`, keeping the low `PA_W` bits. The block then walks all lines, one per cycle, and invalidates any line that already holds the same physical block. This ensures that two aliases never sit in the cache at once. After the walk it refills the line from a word-organised memory model.

Writes are write-through with allocate: a write updates the line and the memory model in the same cycle. A flush input sweeps all lines invalid, taking one cycle per line. While `busy` is high, requests are not accepted.

Top module: `vtag_cache`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `miss_req` are all low.
- R2: Before any write, the memory word at word index w = PA>>2 holds (w * 0x9E3779B1 + 0x13579BDF) mod 2^32. A read that misses returns that word with `resp_hit` = 0.
- R3: Repeating an access with the same virtual address and process number right after its refill hits: `resp_hit` = 1, the data is unchanged and `miss_req` does not pulse.
- R4: With `pid_tag_en` = 1, a line filled under one process number does not hit for a request with the same virtual address under another process number.
- R5: With `pid_tag_en` = 1, a change of process number leaves lines at other indices valid, so they still hit when the earlier process returns.
- R6: With `pid_tag_en` = 0, a lookup whose process number differs from the previous lookup first invalidates every line. Lookups with an unchanged process number hit normally, and the process number is not compared.
- R7: A write updates the cached word and the memory word at once. After the line has been evicted, a read returns the written value.
- R8: The physical block address is the low `PA_W` bits of (byte VA XOR (pid << `PAGE_BITS`)) >> log2(line bytes). Before a refill, every other line holding the same physical block is invalidated. A read through one alias therefore sees a write made through the other, and the invalidated alias misses on its next access.
- R9: A one-cycle `flush` pulse seen while idle holds `busy` high for exactly `LINES` cycles, and every line is invalid afterwards.
- R10: Each miss raises `miss_req` for exactly one cycle, with the translated block on `miss_pblk`. A hit raises no miss request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_tag_en | input | 1 | 1: process number is part of the hit check; 0: a process change sweeps the cache |
| flush | input | 1 | Invalidate all lines (accepted while idle) |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vwa | input | ADDR_W-2 | Virtual word address (byte address >> 2) |
| req_pid | input | PID_W | Process number of the request |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Block is handling a request or a sweep |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 if the first lookup of the request hit |
| resp_rdata | output | 32 | Read data (write data on a write) |
| miss_req | output | 1 | One-cycle translation/refill request on a miss |
| miss_pblk | output | PA_W-log2(LINE_BYTES) | Translated physical block number |

## Verification
The bench builds the cache with 8 lines of 16 bytes, a 10-bit physical space and `PAGE_BITS` = 4. With these values the process number moves physical bits 4 and up, so two virtual addresses in different processes can alias to one block while falling in different line indices. This brings the synonym walk into play. The small configuration also lets the bench sweep every index, keep a full shadow of the 256-word memory, and time the flush sweep to an exact cycle count.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_XLATE,
        ST_SCAN,
        ST_FILL,
        ST_FLUSH
    } vtc_state_e;

    // Power-up content of the memory model, by word index
    function automatic logic [31:0] seed_word(input logic [31:0] widx);
        return widx * 32'h9E3779B1 + 32'h13579BDF;
    endfunction

endpackage

// File: rtl/vtc_xlate.sv
module vtc_xlate #(
    parameter int ADDR_W     = 32,
    parameter int PID_W      = 8,
    parameter int PA_W       = 12,
    parameter int PAGE_BITS  = 8,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-3:0]                     vwa,
    input  logic [PID_W-1:0]                      pid,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]    pblk
);
    localparam int OFF    = $clog2(LINE_BYTES);
    localparam int PBLK_W = PA_W - OFF;

    // Stub mapping: byte address XOR shifted process number
    assign pblk = PBLK_W'(({vwa, 2'b00} ^ (ADDR_W'(pid) << PAGE_BITS)) >> OFF);
endmodule

// File: rtl/vtc_mem.sv
module vtc_mem #(
    parameter int PA_W       = 12,
    parameter int LINE_BYTES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [PA_W-$clog2(LINE_BYTES)-1:0]     blk,
    output logic [LINE_BYTES/4-1:0][31:0]          blk_words,
    input  logic                                   we,
    input  logic [PA_W-3:0]                        waddr,
    input  logic [31:0]                            wdata
);
    localparam int NW   = 2 ** (PA_W - 2);
    localparam int WPL  = LINE_BYTES / 4;
    localparam int WOFF = $clog2(WPL);

    logic [31:0] words_q [NW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) words_q[i] <= vtc_pkg::seed_word(32'(i));
        end else if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    for (genvar w = 0; w < WPL; w++) begin : g_rd
        assign blk_words[w] = words_q[{blk, WOFF'(w)}];
    end
endmodule

// File: rtl/vtag_cache.sv
module vtag_cache #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 64,
    parameter int PID_W      = 8,
    parameter int PA_W       = 12,
    parameter int PAGE_BITS  = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                pid_tag_en,
    input  logic                                flush,
    input  logic                                req_valid,
    input  logic                                req_we,
    input  logic [ADDR_W-3:0]                   req_vwa,
    input  logic [PID_W-1:0]                    req_pid,
    input  logic [31:0]                         req_wdata,
    output logic                                busy,
    output logic                                resp_valid,
    output logic                                resp_hit,
    output logic [31:0]                         resp_rdata,
    output logic                                miss_req,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]  miss_pblk
);
    import vtc_pkg::*;

    localparam int OFF    = $clog2(LINE_BYTES);
    localparam int WPL    = LINE_BYTES / 4;
    localparam int WOFF   = OFF - 2;
    localparam int IDX_W  = $clog2(LINES);
    localparam int VWA_W  = ADDR_W - 2;
    localparam int TAG_W  = ADDR_W - OFF - IDX_W;
    localparam int PBLK_W = PA_W - OFF;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    typedef struct packed {
        logic [TAG_W-1:0]  vtag;
        logic [PID_W-1:0]  pid;
        logic [PBLK_W-1:0] pblk;
    } line_meta_t;

    typedef struct packed {
        logic              we;
        logic [VWA_W-1:0]  vwa;
        logic [PID_W-1:0]  pid;
        logic [31:0]       wdata;
    } req_t;

    vtc_state_e                   state;
    req_t                         q;
    logic [LINES-1:0]             valid_q;
    line_meta_t                   meta_q [LINES];
    logic [WPL-1:0][31:0]         data_q [LINES];
    logic [IDX_W-1:0]             scan_idx;
    logic                         resume_q;
    logic                         missed_q;
    logic [PID_W-1:0]             last_pid_q;
    logic [PBLK_W-1:0]            pblk_q;

    logic [IDX_W-1:0]             q_idx;
    logic [TAG_W-1:0]             q_tag;
    logic [WOFF-1:0]              q_woff;
    line_meta_t                   sel_meta;
    logic                         hit_c;
    logic                         pid_switch;
    logic [PBLK_W-1:0]            xl_pblk;
    logic [WPL-1:0][31:0]         fill_words;
    logic                         mem_we;
    logic                         fill_en;

    assign q_woff     = q.vwa[WOFF-1:0];
    assign q_idx      = q.vwa[WOFF +: IDX_W];
    assign q_tag      = q.vwa[VWA_W-1 -: TAG_W];
    assign sel_meta   = meta_q[q_idx];
    assign hit_c      = valid_q[q_idx] && (sel_meta.vtag == q_tag)
                        && (!pid_tag_en || (sel_meta.pid == q.pid));
    assign pid_switch = !pid_tag_en && (q.pid != last_pid_q);
    assign mem_we     = (state == ST_LOOK) && !pid_switch && hit_c && q.we;
    assign fill_en    = (state == ST_FILL);

    assign busy      = (state != ST_IDLE);
    assign miss_req  = (state == ST_XLATE);
    assign miss_pblk = xl_pblk;

    vtc_xlate #(
        .ADDR_W(ADDR_W), .PID_W(PID_W), .PA_W(PA_W),
        .PAGE_BITS(PAGE_BITS), .LINE_BYTES(LINE_BYTES)
    ) xlate_i (
        .vwa  (q.vwa),
        .pid  (q.pid),
        .pblk (xl_pblk)
    );

    vtc_mem #(.PA_W(PA_W), .LINE_BYTES(LINE_BYTES)) mem_i (
        .clk       (clk),
        .rst       (rst),
        .blk       (pblk_q),
        .blk_words (fill_words),
        .we        (mem_we),
        .waddr     ({sel_meta.pblk, q_woff}),
        .wdata     (q.wdata)
    );

    // Line storage (no reset; guarded by valid_q)
    always_ff @(posedge clk) begin
        if (fill_en) begin
            meta_q[q_idx] <= '{vtag: q_tag, pid: q.pid, pblk: pblk_q};
            data_q[q_idx] <= fill_words;
        end else if (mem_we) begin
            data_q[q_idx][q_woff] <= q.wdata;
        end
    end

    // Control
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            q          <= '0;
            valid_q    <= '0;
            scan_idx   <= '0;
            resume_q   <= 1'b0;
            missed_q   <= 1'b0;
            last_pid_q <= '0;
            pblk_q     <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (flush) begin
                        scan_idx <= '0;
                        resume_q <= 1'b0;
                        state    <= ST_FLUSH;
                    end else if (req_valid) begin
                        q        <= '{we: req_we, vwa: req_vwa, pid: req_pid, wdata: req_wdata};
                        missed_q <= 1'b0;
                        state    <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    last_pid_q <= q.pid;
                    if (pid_switch) begin
                        scan_idx <= '0;
                        resume_q <= 1'b1;
                        state    <= ST_FLUSH;
                    end else if (hit_c) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= !missed_q;
                        resp_rdata <= q.we ? q.wdata : data_q[q_idx][q_woff];
                        state      <= ST_IDLE;
                    end else begin
                        missed_q <= 1'b1;
                        state    <= ST_XLATE;
                    end
                end
                ST_XLATE: begin
                    pblk_q   <= xl_pblk;
                    scan_idx <= '0;
                    state    <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (valid_q[scan_idx] && (meta_q[scan_idx].pblk == pblk_q))
                        valid_q[scan_idx] <= 1'b0;
                    if (scan_idx == LAST) state <= ST_FILL;
                    else                  scan_idx <= scan_idx + 1'b1;
                end
                ST_FILL: begin
                    valid_q[q_idx] <= 1'b1;
                    state          <= ST_LOOK;
                end
                ST_FLUSH: begin
                    valid_q[scan_idx] <= 1'b0;
                    if (scan_idx == LAST) state <= resume_q ? ST_LOOK : ST_IDLE;
                    else                  scan_idx <= scan_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Number of valid lines already holding the block about to be filled
    int dup_cnt;
    always_comb begin
        dup_cnt = 0;
        for (int i = 0; i < LINES; i++)
            if (valid_q[i] && (meta_q[i].pblk == pblk_q)) dup_cnt++;
    end

    assert_no_alias_at_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL) |-> (dup_cnt == 0));

    assert_refill_then_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL) |=> hit_c);

    assert_sweep_empties_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH && scan_idx == LAST) |=> (valid_q == '0));

    assert_resp_single_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_miss_single_R10: assert property (@(posedge clk) disable iff (rst)
        miss_req |=> (!miss_req && busy));
endmodule

// File: tb/vtag_cache_tb_top.sv
module vtag_cache_tb_top;
    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pid_tag_en = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [29:0] req_vwa = '0;
    logic [7:0]  req_pid = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, resp_valid, resp_hit, miss_req;
    logic [31:0] resp_rdata;
    logic [5:0]  miss_pblk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] shadow [256];

    always #10 clk = ~clk;

    vtag_cache #(
        .ADDR_W(32), .LINE_BYTES(16), .LINES(LINES),
        .PID_W(8), .PA_W(10), .PAGE_BITS(4)
    ) dut_i (
        .clk(clk), .rst(rst), .pid_tag_en(pid_tag_en), .flush(flush),
        .req_valid(req_valid), .req_we(req_we), .req_vwa(req_vwa),
        .req_pid(req_pid), .req_wdata(req_wdata), .busy(busy),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .miss_req(miss_req), .miss_pblk(miss_pblk)
    );

    function automatic int widx(input logic [31:0] va, input logic [7:0] pid);
        logic [31:0] pa;
        pa = (va ^ (32'(pid) << 4)) & 32'h3FF;
        return int'(pa >> 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [31:0] va, input logic [7:0] pid,
                       input logic [31:0] wd, output logic hit, output logic [31:0] rd,
                       output int nmiss);
        int guard;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_vwa = va[31:2]; req_pid = pid; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        nmiss = 0; guard = 0;
        while (!resp_valid && guard < 2000) begin
            if (miss_req) nmiss++;
            @(negedge clk);
            guard++;
        end
        hit = resp_hit;
        rd  = resp_rdata;
    endtask

    task automatic rd_chk(input logic [31:0] va, input logic [7:0] pid,
                          input bit exp_hit, input string req);
        logic h; logic [31:0] d; int nm;
        acc(1'b0, va, pid, 32'h0, h, d, nm);
        chk({req, " hit"}, 32'(h), 32'(exp_hit));
        chk({req, " data"}, d, shadow[widx(va, pid)]);
        chk({req, " R10 miss pulses"}, 32'(nm), exp_hit ? 32'd0 : 32'd1);
    endtask

    task automatic wr_chk(input logic [31:0] va, input logic [7:0] pid,
                          input logic [31:0] wd, input bit exp_hit, input string req);
        logic h; logic [31:0] d; int nm;
        acc(1'b1, va, pid, wd, h, d, nm);
        shadow[widx(va, pid)] = wd;
        chk({req, " write hit"}, 32'(h), 32'(exp_hit));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        for (int i = 0; i < 256; i++) shadow[i] = 32'(i) * 32'h9E3779B1 + 32'h13579BDF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 resp_valid", 32'(resp_valid), 32'd0);
        chk("R1 miss_req", 32'(miss_req), 32'd0);

        // R2 / R3 / R10: sweep every index under process 1
        for (int i = 0; i < LINES; i++) begin
            logic [31:0] va;
            va = 32'(i * 16 + (i % 4) * 4);
            rd_chk(va, 8'd1, 1'b0, "R2 sweep miss");
            rd_chk(va, 8'd1, 1'b1, "R3 sweep hit");
        end

        // R4: same VA, other process misses; R5: other index survives switch
        rd_chk(32'h000, 8'd2, 1'b0, "R4 other pid");
        rd_chk(32'h010, 8'd1, 1'b1, "R5 survivor");

        // R7: write-through survives eviction
        wr_chk(32'h020, 8'd1, 32'hCAFE0001, 1'b1, "R7");
        rd_chk(32'h0A0, 8'd1, 1'b0, "R7 evict");
        rd_chk(32'h020, 8'd1, 1'b0, "R7 reread");

        // R8: alias 0x040/pid0 and 0x050/pid1 share physical block 0x040
        rd_chk(32'h040, 8'd0, 1'b0, "R8 first alias");
        wr_chk(32'h050, 8'd1, 32'hBEEF0002, 1'b0, "R8");
        rd_chk(32'h040, 8'd0, 1'b0, "R8 alias sees write");
        rd_chk(32'h050, 8'd1, 1'b0, "R8 other alias dropped");

        // R9: flush sweep length and effect
        rd_chk(32'h060, 8'd1, 1'b1, "R9 before flush");
        @(negedge clk);
        while (busy) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R9 busy cycles", 32'(cnt), 32'(LINES));
        rd_chk(32'h060, 8'd1, 1'b0, "R9 after flush");

        // R6: untagged mode, process change sweeps the cache
        pid_tag_en = 1'b0;
        rd_chk(32'h070, 8'd3, 1'b0, "R6 switch to 3");
        rd_chk(32'h000, 8'd3, 1'b0, "R6 fill 3");
        rd_chk(32'h070, 8'd3, 1'b1, "R6 same pid hit");
        rd_chk(32'h000, 8'd4, 1'b0, "R6 switch to 4");
        rd_chk(32'h070, 8'd4, 1'b0, "R6 swept line");
        rd_chk(32'h000, 8'd4, 1'b1, "R6 pid 4 hit");

        finish_run();
    end
endmodule